// File: doc/BRIEF.md
# Rail Pulse-Width Packet Receiver

This block sits on the car side of a digital slot-car track. It watches one rail of the track signal and times each full cycle, from one rising edge to the next, in microsecond ticks. A short cycle is a one bit and a long cycle is a zero bit. Zero bits may be stretched far past their nominal length. A cycle outside both windows, or a quiet rail that runs past a timeout, is invalid.

From the stream of bits the block finds a packet lead-in, assembles eight bytes and checks that the last byte matches the running XOR checksum. When a packet is good it updates two outputs: the command byte, and the byte for the car slot chosen by the `car_id_i` input. It also splits the slot byte into brake, lane-change and speed fields, and pulses `valid_o`. When a packet is rejected, the outputs keep their previous values and `err_o` pulses instead.

Top module: `railpkt_rx`

## Requirements
- R1: A cycle of TONE_MIN to TONE_MAX ticks (defaults 95 and 137) is taken as a one bit.
- R2: A cycle of TZERO_MIN ticks (default 185) up to TMO_TICKS ticks (default 2000) is taken as a zero bit. This includes zeros stretched to several times their nominal length.
- R3: The following abort a packet in progress, return the receiver to lead-in search and pulse `err_o`: a cycle shorter than TONE_MIN, a cycle between TONE_MAX and TZERO_MIN, or a rail that shows no rising edge for (TMO_TICKS+1) ticks. The timeout error is raised as soon as that count is reached. Outside a packet, such a cycle only clears the lead-in count.
- R4: A packet starts only when a zero follows at least LEADIN_MIN (default 10) consecutive one bits. A shorter lead-in produces neither `valid_o` nor `err_o`.
- R5: Each packet has eight bytes, each sent MSB first, with a zero before every byte and a one after the last byte. A one in place of a separator, or a zero in place of the end bit, pulses `err_o`.
- R6: A packet is accepted only if 0xFF XOR bytes 0 to 6 equals byte 7. On a mismatch, `err_o` pulses and `cmd_o` and `slot_o` keep their values.
- R7: Byte 0 is the command. Only the values 0, 1 and 2 are accepted. Any other value pulses `err_o`.
- R8: For `car_id_i` = n with 1 <= n <= 6, `slot_o` takes byte n of the packet. For any other ID, an accepted packet sets `slot_o` to 0.
- R9: `brake_o` is `slot_o` bit 7, `lane_o` is bit 6, and `speed_o` is bits 5:0 (0x3F is full speed, 0 is off).
- R10: After reset all outputs are 0. The rail passes through two synchronising flip-flops, and cycles are timed between synchronised rising edges. When the rising edge that closes the end bit is first sampled on a clock edge, `valid_o` rises after the third clock edge that follows and lasts one clock.
- R11: `err_o` lasts one clock, is never high together with `valid_o`, and leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rail_i | input | 1 | Rail level, asynchronous to the clock |
| car_id_i | input | 3 | Car ID that selects the slot byte |
| cmd_o | output | 8 | Command byte of the last accepted packet |
| slot_o | output | 8 | Slot byte for this car from the last accepted packet |
| brake_o | output | 1 | Brake flag |
| lane_o | output | 1 | Lane-change flag |
| speed_o | output | 6 | Speed value |
| valid_o | output | 1 | One-clock pulse when a packet is accepted |
| err_o | output | 1 | One-clock pulse when a packet is rejected or aborted |

## Verification
The bench builds the block with TICK_DIV=2 and scaled windows: a one is 10 to 14 ticks, a zero is 19 to 80 ticks, the timeout is 80 ticks and the lead-in is 10. With these values every edge of both windows, a stretched zero of 60 ticks, the gap and short cycles, and a real timeout each fit into a few thousand clocks per packet. Many whole packets can therefore be sent, including bad checksums, illegal commands, broken separators and end bits, a short lead-in, and every car ID class. A behavioural model built from timestamps and queues predicts the outputs on every clock.

// File: rtl/railpkt_pkg.sv
package railpkt_pkg;
  localparam int PKT_BYTES = 8;
  localparam int BYTE_BITS = 8;
  localparam int NUM_SLOTS = PKT_BYTES - 2;
  localparam int ID_W      = 3;
  localparam int IDX_W     = $clog2(PKT_BYTES);
  localparam int BIT_W     = $clog2(BYTE_BITS);
  localparam logic [7:0] CSUM_SEED = 8'hFF;
  localparam logic [7:0] CMD_MAX   = 8'd2;

  typedef enum logic [1:0] {SYM_ONE, SYM_ZERO, SYM_BAD} sym_e;
  typedef enum logic [1:0] {ST_HUNT, ST_DATA, ST_SEP, ST_END} rx_st_e;
endpackage

// File: rtl/railpkt_sync.sv
module railpkt_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rail_i,
  output logic rise_o
);
  logic [2:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_q <= '0;
    else         s_q <= {s_q[1:0], rail_i};
  end

  assign rise_o = s_q[1] & ~s_q[2];
endmodule

// File: rtl/railpkt_meter.sv
module railpkt_meter
  import railpkt_pkg::*;
#(
  parameter int TICK_DIV  = 50,
  parameter int TONE_MIN  = 95,
  parameter int TONE_MAX  = 137,
  parameter int TZERO_MIN = 185,
  parameter int TMO_TICKS = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  output logic sym_vld_o,
  output sym_e sym_o,
  output logic tmo_o
);
  localparam int CNT_W = $clog2(TMO_TICKS + 2);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] SAT    = CNT_W'(TMO_TICKS + 1);
  localparam logic [CNT_W-1:0] ONE_LO = CNT_W'(TONE_MIN);
  localparam logic [CNT_W-1:0] ONE_HI = CNT_W'(TONE_MAX);
  localparam logic [CNT_W-1:0] ZER_LO = CNT_W'(TZERO_MIN);
  localparam logic [CNT_W-1:0] ZER_HI = CNT_W'(TMO_TICKS);
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             wrap;
  sym_e             cls;

  always_comb begin
    wrap    = (pre_q == PRE_TOP);
    cnt_nxt = (wrap && cnt_q != SAT) ? cnt_q + CNT_W'(1) : cnt_q;
    if (cnt_nxt >= ONE_LO && cnt_nxt <= ONE_HI)      cls = SYM_ONE;
    else if (cnt_nxt >= ZER_LO && cnt_nxt <= ZER_HI) cls = SYM_ZERO;
    else                                             cls = SYM_BAD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q     <= '0;
      cnt_q     <= SAT;   // no reference edge yet
      sym_vld_o <= 1'b0;
      sym_o     <= SYM_BAD;
      tmo_o     <= 1'b0;
    end else if (rise_i) begin
      pre_q     <= '0;
      cnt_q     <= '0;
      sym_vld_o <= 1'b1;
      sym_o     <= cls;
      tmo_o     <= 1'b0;
    end else begin
      pre_q     <= wrap ? '0 : pre_q + PRE_W'(1);
      cnt_q     <= cnt_nxt;
      sym_vld_o <= 1'b0;
      tmo_o     <= (cnt_q != SAT) && (cnt_nxt == SAT);
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) cnt_q <= SAT);
  // R3
  tmo_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) tmo_o |=> !tmo_o);
  // R3
  tmo_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) tmo_o |-> !sym_vld_o);
endmodule

// File: rtl/railpkt_framer.sv
module railpkt_framer
  import railpkt_pkg::*;
#(
  parameter int LEADIN_MIN = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sym_vld_i,
  input  sym_e            sym_i,
  input  logic            tmo_i,
  input  logic [ID_W-1:0] car_id_i,
  output logic [7:0]      cmd_o,
  output logic [7:0]      slot_o,
  output logic            valid_o,
  output logic            err_o
);
  localparam int ONES_W = $clog2(LEADIN_MIN + 1);
  localparam logic [ONES_W-1:0] LEAD_L   = ONES_W'(LEADIN_MIN);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(PKT_BYTES - 1);
  localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(BYTE_BITS - 1);

  rx_st_e            st_q;
  logic [ONES_W-1:0] ones_q;
  logic [7:0]        sh_q, byte_nxt, csum_q, cmd_pend_q, slot_pend_q;
  logic [BIT_W-1:0]  bit_q;
  logic [IDX_W-1:0]  byte_q;
  logic              csum_ok_q, car_ok, slot_hit;

  assign byte_nxt = {sh_q[6:0], sym_i == SYM_ONE};
  assign car_ok   = (car_id_i != '0) && (car_id_i <= ID_W'(NUM_SLOTS));
  assign slot_hit = car_ok && (IDX_W'(car_id_i) == byte_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_HUNT; ones_q <= '0; sh_q <= '0; bit_q <= '0; byte_q <= '0;
      csum_q <= CSUM_SEED; csum_ok_q <= 1'b0; cmd_pend_q <= '0; slot_pend_q <= '0;
      cmd_o <= '0; slot_o <= '0; valid_o <= 1'b0; err_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      if (tmo_i) begin
        err_o  <= (st_q != ST_HUNT);
        st_q   <= ST_HUNT;
        ones_q <= '0;
      end else if (sym_vld_i) begin
        unique case (st_q)
          ST_HUNT: begin
            case (sym_i)
              SYM_ONE:  if (ones_q != LEAD_L) ones_q <= ones_q + ONES_W'(1);
              SYM_ZERO: begin
                ones_q <= '0;
                if (ones_q == LEAD_L) begin
                  st_q <= ST_DATA; byte_q <= '0; bit_q <= '0;
                  csum_q <= CSUM_SEED; slot_pend_q <= '0;
                end
              end
              default:  ones_q <= '0;
            endcase
          end
          ST_DATA: begin
            if (sym_i == SYM_BAD) begin
              err_o <= 1'b1; st_q <= ST_HUNT; ones_q <= '0;
            end else begin
              sh_q  <= byte_nxt;
              bit_q <= bit_q + BIT_W'(1);
              if (bit_q == LAST_BIT) begin
                if (byte_q == '0) cmd_pend_q <= byte_nxt;
                if (slot_hit)     slot_pend_q <= byte_nxt;
                if (byte_q == LAST_IDX) begin
                  csum_ok_q <= (byte_nxt == csum_q);
                  st_q      <= ST_END;
                end else begin
                  csum_q <= csum_q ^ byte_nxt;
                  st_q   <= ST_SEP;
                end
              end
            end
          end
          ST_SEP: begin
            if (sym_i == SYM_ZERO) begin
              byte_q <= byte_q + IDX_W'(1); bit_q <= '0; st_q <= ST_DATA;
            end else begin
              err_o  <= 1'b1; st_q <= ST_HUNT;
              ones_q <= (sym_i == SYM_ONE) ? ONES_W'(1) : '0;
            end
          end
          ST_END: begin
            if (sym_i == SYM_ONE && csum_ok_q && cmd_pend_q <= CMD_MAX) begin
              cmd_o <= cmd_pend_q; slot_o <= slot_pend_q; valid_o <= 1'b1;
            end else begin
              err_o <= 1'b1;
            end
            st_q   <= ST_HUNT;
            ones_q <= '0;
          end
          default: st_q <= ST_HUNT;
        endcase
      end
    end
  end

  // R4
  start_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == ST_HUNT && st_q == ST_DATA) |-> $past(ones_q) == LEAD_L);
  // R7
  cmd_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_o |-> cmd_o <= CMD_MAX);
  // R10
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_o |=> !valid_o);
  // R11
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($stable(cmd_o) && $stable(slot_o)));
  // R11
  no_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !(valid_o && err_o));
endmodule

// File: rtl/railpkt_rx.sv
module railpkt_rx
  import railpkt_pkg::*;
#(
  parameter int TICK_DIV   = 50,
  parameter int TONE_MIN   = 95,
  parameter int TONE_MAX   = 137,
  parameter int TZERO_MIN  = 185,
  parameter int TMO_TICKS  = 2000,
  parameter int LEADIN_MIN = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rail_i,
  input  logic [2:0] car_id_i,
  output logic [7:0] cmd_o,
  output logic [7:0] slot_o,
  output logic       brake_o,
  output logic       lane_o,
  output logic [5:0] speed_o,
  output logic       valid_o,
  output logic       err_o
);
  logic rise, sym_vld, tmo;
  sym_e sym;

  railpkt_sync i_sync (.clk_i, .rst_ni, .rail_i, .rise_o(rise));

  railpkt_meter #(
    .TICK_DIV(TICK_DIV), .TONE_MIN(TONE_MIN), .TONE_MAX(TONE_MAX),
    .TZERO_MIN(TZERO_MIN), .TMO_TICKS(TMO_TICKS)
  ) i_meter (
    .clk_i, .rst_ni, .rise_i(rise), .sym_vld_o(sym_vld), .sym_o(sym), .tmo_o(tmo)
  );

  railpkt_framer #(.LEADIN_MIN(LEADIN_MIN)) i_framer (
    .clk_i, .rst_ni, .sym_vld_i(sym_vld), .sym_i(sym), .tmo_i(tmo),
    .car_id_i, .cmd_o, .slot_o, .valid_o, .err_o
  );

  assign brake_o = slot_o[7];
  assign lane_o  = slot_o[6];
  assign speed_o = slot_o[5:0];
endmodule

// File: tb/test_railpkt_rx.sv
module test_railpkt_rx;
  localparam int DIV = 2, OMIN = 10, OMAX = 14, ZMIN = 19, TMO = 80, LEAD = 10;

  logic clk = 1'b0, rst_ni = 1'b0, rail = 1'b0;
  logic [2:0] car_id = 3'd0;
  logic [7:0] cmd_o, slot_o;
  logic brake_o, lane_o, valid_o, err_o;
  logic [5:0] speed_o;

  always #2 clk = ~clk;

  railpkt_rx #(.TICK_DIV(DIV), .TONE_MIN(OMIN), .TONE_MAX(OMAX), .TZERO_MIN(ZMIN),
               .TMO_TICKS(TMO), .LEADIN_MIN(LEAD)) i_railpkt_rx (
    .clk_i(clk), .rst_ni, .rail_i(rail), .car_id_i(car_id), .cmd_o, .slot_o,
    .brake_o, .lane_o, .speed_o, .valid_o, .err_o);

  int vecs = 0, fails = 0, nv = 0, ne = 0;
  bit done = 0;

  task automatic check_eq(string tag, int act, int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  bit hq[$];
  int g, m_st, m_ones, m_nb, m_cur, m_idx;
  int m_b[8];
  bit pend_v, pend_e, exp_v, exp_e;
  int pend_cmd, pend_slot, exp_cmd, exp_slot;

  task automatic m_abort(int ones);
    if (m_st != 0) pend_e = 1;
    m_st = 0; m_ones = ones;
  endtask

  task automatic m_sym(int s); // 0 one, 1 zero, 2 bad
    int x;
    case (m_st)
      0: if (s == 0) m_ones++;
         else begin
           if (s == 1 && m_ones >= LEAD) begin m_st = 1; m_idx = 0; m_nb = 0; m_cur = 0; end
           m_ones = 0;
         end
      1: if (s == 2) m_abort(0);
         else begin
           m_cur = (m_cur << 1) | (s == 0 ? 1 : 0); m_nb++;
           if (m_nb == 8) begin
             m_b[m_idx] = m_cur; m_cur = 0; m_nb = 0;
             m_st = (m_idx == 7) ? 3 : 2;
           end
         end
      2: if (s == 1) begin m_idx++; m_st = 1; end
         else m_abort(s == 0 ? 1 : 0);
      default: begin
        x = 'hFF;
        for (int i = 0; i < 7; i++) x ^= m_b[i];
        if (s == 0 && x == m_b[7] && m_b[0] <= 2) begin
          pend_v = 1; pend_cmd = m_b[0];
          pend_slot = (car_id >= 1 && car_id <= 6) ? m_b[car_id] : 0;
        end else pend_e = 1;
        m_st = 0; m_ones = 0;
      end
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_ni) begin
      hq = '{0, 0, 0}; g = 1000000; m_st = 0; m_ones = 0; m_nb = 0; m_cur = 0; m_idx = 0;
      pend_v = 0; pend_e = 0; exp_v = 0; exp_e = 0;
      pend_cmd = 0; pend_slot = 0; exp_cmd = 0; exp_slot = 0;
    end else begin
      int n, t;
      exp_v = pend_v; exp_e = pend_e; exp_cmd = pend_cmd; exp_slot = pend_slot;
      pend_v = 0; pend_e = 0;
      if (hq[1] && !hq[0]) begin
        n = g + 1; g = 0; t = n / DIV;
        if (t >= OMIN && t <= OMAX)     m_sym(0);
        else if (t >= ZMIN && t <= TMO) m_sym(1);
        else                            m_sym(2);
      end else begin
        if (g < 1000000) g++;
        if (g == (TMO + 1) * DIV) m_abort(0);
      end
      hq.push_back(rail); void'(hq.pop_front());
    end
  end

  always @(negedge clk) if (rst_ni && !done) begin
    check_eq("R10 valid_o", valid_o, exp_v);
    check_eq("R11 err_o", err_o, exp_e);
    check_eq("R8 cmd_o", cmd_o, exp_cmd);
    check_eq("R8 slot_o", slot_o, exp_slot);
    check_eq("R9 fields", {brake_o, lane_o, speed_o}, exp_slot);
    if (valid_o) nv++;
    if (err_o) ne++;
  end

  task automatic cyc(int t);
    int p = t * DIV;
    rail = 1'b1; repeat (p / 2) @(negedge clk);
    rail = 1'b0; repeat (p - p / 2) @(negedge clk);
  endtask

  function automatic logic [63:0] mk(logic [7:0] c, a, b, d, e, f, h);
    logic [7:0] x = 8'hFF ^ c ^ a ^ b ^ d ^ e ^ f ^ h;
    return {c, a, b, d, e, f, h, x};
  endfunction

  // mode 0 normal, 1 abort cycle of abt ticks in byte 2, 2 one as separator of byte 3, 3 zero end bit
  task automatic send_pkt(logic [63:0] pk, int lead, int ot, int zt, int mode, int abt);
    cyc(5);
    repeat (lead) cyc(ot);
    for (int i = 0; i < 8; i++) begin
      cyc((mode == 2 && i == 3) ? ot : zt);
      for (int j = 7; j >= 0; j--) begin
        if (mode == 1 && i == 2 && j == 4) begin cyc(abt); cyc(ot); cyc(ot); return; end
        cyc(pk[56 - 8 * i + j] ? ot : zt);
      end
    end
    cyc(mode == 3 ? zt : ot);
    cyc(ot); cyc(ot);
  endtask

  task automatic expect_pulses(string tag, int v0, int e0, int dv, int de);
    check_eq({tag, " valid count"}, nv - v0, dv);
    check_eq({tag, " err count"}, ne - e0, de);
  endtask

  task automatic expect_out(string tag, int c, int s);
    check_eq({tag, " cmd"}, cmd_o, c);
    check_eq({tag, " slot"}, slot_o, s);
    check_eq("R9 brake", brake_o, s[7]);
    check_eq("R9 lane", lane_o, s[6]);
    check_eq("R9 speed", speed_o, s[5:0]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++; done = 1;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] pa, pb;
    int v0, e0;
    pa = mk(8'h02, 8'h3F, 8'h53, 8'h80, 8'h00, 8'h21, 8'h4F);
    pb = mk(8'h02, 8'h9A, 8'h41, 8'hC5, 8'h7E, 8'h01, 8'h3C);
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R10 reset state
    check_eq("R10 reset valid", valid_o, 0);
    check_eq("R11 reset err", err_o, 0);
    expect_out("R10 reset", 0, 0);

    // R5 R6 R8 nominal packet, car 3
    car_id = 3; v0 = nv; e0 = ne;
    send_pkt(pa, 12, 12, 24, 0, 0);
    expect_pulses("R5", v0, e0, 1, 0);
    expect_out("R8 car3", 2, 8'h80);

    // R2 stretched zeros, car 2
    car_id = 2; v0 = nv; e0 = ne;
    send_pkt(pa, 12, 12, 60, 0, 0);
    expect_pulses("R2 stretched", v0, e0, 1, 0);
    expect_out("R2 car2", 2, 8'h53);

    // R1 R2 window minimums, car 6
    car_id = 6; v0 = nv; e0 = ne;
    send_pkt(pb, 10, OMIN, ZMIN, 0, 0);
    expect_pulses("R1 min", v0, e0, 1, 0);
    expect_out("R8 car6", 2, 8'h3C);

    // R1 R2 window maximums, car 1
    car_id = 1; v0 = nv; e0 = ne;
    send_pkt(pa, 10, OMAX, TMO, 0, 0);
    expect_pulses("R1 max", v0, e0, 1, 0);
    expect_out("R8 car1", 2, 8'h3F);

    // R6 bad checksum
    car_id = 3; v0 = nv; e0 = ne;
    send_pkt(pb ^ 64'h1, 12, 12, 24, 0, 0);
    expect_pulses("R6 checksum", v0, e0, 0, 1);
    expect_out("R6 held", 2, 8'h3F);

    // R7 illegal command
    v0 = nv; e0 = ne;
    send_pkt(mk(8'h03, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66), 12, 12, 24, 0, 0);
    expect_pulses("R7 cmd3", v0, e0, 0, 1);
    expect_out("R7 held", 2, 8'h3F);

    // R7 commands 0 and 1, R8 id 4 and id 0
    car_id = 4; v0 = nv; e0 = ne;
    send_pkt(mk(8'h00, 8'h04, 8'h04, 8'h04, 8'h04, 8'h04, 8'h04), 12, 12, 24, 0, 0);
    expect_pulses("R7 cmd0", v0, e0, 1, 0);
    expect_out("R7 cmd0", 0, 8'h04);
    car_id = 0; v0 = nv; e0 = ne;
    send_pkt(mk(8'h01, 8'h05, 8'h05, 8'h05, 8'h05, 8'h05, 8'h05), 12, 12, 24, 0, 0);
    expect_pulses("R7 cmd1", v0, e0, 1, 0);
    expect_out("R8 id0", 1, 8'h00);

    // R4 lead-in one short
    car_id = 3; v0 = nv; e0 = ne;
    send_pkt(pa, 9, 12, 24, 0, 0);
    expect_pulses("R4 lead9", v0, e0, 0, 0);
    expect_out("R4 held", 1, 8'h00);

    // R3 gap cycle, short cycle, timeout
    v0 = nv; e0 = ne;
    send_pkt(pa, 12, 12, 24, 1, 16);
    expect_pulses("R3 gap", v0, e0, 0, 1);
    v0 = nv; e0 = ne;
    send_pkt(pa, 12, 12, 24, 1, 8);
    expect_pulses("R3 short", v0, e0, 0, 1);
    v0 = nv; e0 = ne;
    send_pkt(pa, 12, 12, 24, 1, 100);
    expect_pulses("R3 timeout", v0, e0, 0, 1);

    // R5 broken separator and end bit
    v0 = nv; e0 = ne;
    send_pkt(pa, 12, 12, 24, 2, 0);
    expect_pulses("R5 separator", v0, e0, 0, 1);
    v0 = nv; e0 = ne;
    send_pkt(pa, 12, 12, 24, 3, 0);
    expect_pulses("R5 endbit", v0, e0, 0, 1);
    expect_out("R11 held", 1, 8'h00);

    // R3 recovery after aborts
    v0 = nv; e0 = ne;
    send_pkt(pa, 12, 12, 24, 0, 0);
    expect_pulses("R3 recover", v0, e0, 1, 0);
    expect_out("R3 recover", 2, 8'h80);

    repeat (10) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule